// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block keeps the loads and stores of an out-of-order core in program order and decides, each cycle, which of them may access the data cache. Dispatch writes an entry for each memory operation in program order. The address unit later supplies the entry's effective address once its register operands are resolved. The reorder buffer marks each entry committed when the operation has become the oldest uncommitted instruction. The cache accepts whatever the queue offers on its two issue outputs in the same cycle.

A load goes to the cache as soon as its own address is known and every older store still in the queue has a known address that differs from the load's address. The test is a full address comparison. When several loads qualify, the oldest one goes first. Stores are never speculative. A store writes memory only when it is the oldest entry in the queue, has been committed, and has a known address.

An entry leaves the queue from the head once it has been both issued and committed. A flush request removes every entry younger than a named entry, which lets the core discard a mispredicted path. The queue holds a parameterised number of entries, 8 by default, which must be a power of two.

Top module: `lsq_order_top`

## Requirements
- R1: Each accepted allocation takes the entry index shown on `alloc_idx`. The index advances by one per allocation and wraps from DEPTH-1 to 0, so entries stay in program order. `alloc_is_store` = 1 marks a store and 0 marks a load.
- R2: With DEPTH live entries, `alloc_ready` is 0. A request made in that state is ignored, and `alloc_idx` does not move.
- R3: A load whose own address has not been supplied is never offered on the load issue output.
- R4: An older store in the queue whose address is unknown holds back every younger load, including loads whose addresses are known.
- R5: An older store whose address equals a load's address holds that load back. A younger load with a different address is still offered.
- R6: At most one load is offered per cycle. When several loads are eligible, the one closest to the head (the oldest) is offered first.
- R7: A store is offered only when it is the head entry, has been committed, and has a known address. A committed store behind an older entry is not offered.
- R8: Each entry is offered to the cache at most once.
- R9: The head entry leaves the queue in the cycle after it is both issued and committed, at most one per cycle. This frees a slot for allocation.
- R10: A flush naming entry F removes all entries younger than F. After the flush, `alloc_idx` is F+1, and `alloc_ready` is 0 during the flush cycle. An address update aimed at a removed entry has no effect, and a newly allocated entry starts with no address.
- R11: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, and neither issue output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a new entry |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | Queue can accept an entry this cycle |
| alloc_idx | output | IDXW | Index the next entry receives |
| addr_valid | input | 1 | Effective address update |
| addr_idx | input | IDXW | Entry receiving the address |
| addr_value | input | ADDR_W | Effective address |
| commit_valid | input | 1 | Reorder buffer commits an entry |
| commit_idx | input | IDXW | Entry being committed |
| flush_valid | input | 1 | Discard entries younger than flush_idx |
| flush_idx | input | IDXW | Youngest entry kept |
| ld_issue_valid | output | 1 | A load is sent to the cache |
| ld_issue_idx | output | IDXW | Entry of that load |
| ld_issue_addr | output | ADDR_W | Address of that load |
| st_issue_valid | output | 1 | A store is sent to the cache |
| st_issue_idx | output | IDXW | Entry of that store |
| st_issue_addr | output | ADDR_W | Address of that store |

## Verification
The main stream mixes loads and stores and supplies addresses out of order. It covers four cases separately: an unresolved older store, an older store whose address matches, an older store whose address differs, and a load still waiting for its own address. Each case produces a different load being offered, or none. A second pattern resolves three loads behind a blocking store and then unblocks them together, so only oldest-first selection gives the expected sequence of indices. Separate runs fill the queue across the wrap point and commit a store that is not at the head. They also flush around a partly resolved entry, which distinguishes a head-only store release and the discarding of stale addresses from looser behaviour.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // Per-entry status kept alongside the stored address
  typedef struct packed {
    logic valid;
    logic is_store;
    logic addr_known;
    logic issued;
    logic committed;
  } lsq_flags_t;
endpackage

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [IDXW-1:0]  head,
  output logic             found,
  output logic [IDXW-1:0]  idx
);
  logic [IDXW-1:0] cand;

  // Walk from youngest to oldest position so the oldest request wins
  always_comb begin
    found = 1'b0;
    idx   = head;
    cand  = head;
    for (int off = DEPTH - 1; off >= 0; off--) begin
      cand = head + IDXW'(off);
      if (req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/lsq_dep_check.sv
module lsq_dep_check
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  lsq_flags_t        flags [DEPTH],
  input  logic [ADDR_W-1:0] addr  [DEPTH],
  input  logic [IDXW-1:0]   head,
  output logic [DEPTH-1:0]  ld_ready
);
  logic [IDXW-1:0] age [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age[k] = IDXW'(k) - head;
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_ld
    logic blocked;
    always_comb begin
      blocked = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (flags[i].valid && flags[i].is_store && (age[i] < age[j])) begin
          if (!flags[i].addr_known || (addr[i] == addr[j])) blocked = 1'b1;
        end
      end
    end
    assign ld_ready[j] = flags[j].valid && !flags[j].is_store &&
                         flags[j].addr_known && !flags[j].issued && !blocked;
  end
endmodule

// File: rtl/lsq_order_top.sv
module lsq_order_top
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  output logic              alloc_ready,
  output logic [IDXW-1:0]   alloc_idx,
  input  logic              addr_valid,
  input  logic [IDXW-1:0]   addr_idx,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              commit_valid,
  input  logic [IDXW-1:0]   commit_idx,
  input  logic              flush_valid,
  input  logic [IDXW-1:0]   flush_idx,
  output logic              ld_issue_valid,
  output logic [IDXW-1:0]   ld_issue_idx,
  output logic [ADDR_W-1:0] ld_issue_addr,
  output logic              st_issue_valid,
  output logic [IDXW-1:0]   st_issue_idx,
  output logic [ADDR_W-1:0] st_issue_addr
);
  lsq_flags_t        flags_q [DEPTH];
  lsq_flags_t        flags_n [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [ADDR_W-1:0] addr_n  [DEPTH];
  logic [IDXW-1:0]   head_q, head_n, tail_q, tail_n;
  logic [CNTW-1:0]   cnt_q, cnt_n;

  logic [DEPTH-1:0]  ld_ready;
  logic [IDXW-1:0]   age [DEPTH];
  logic [IDXW-1:0]   flush_age;
  logic              alloc_fire, retire, flush_hit, commit_hit, addr_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age[k] = IDXW'(k) - head_q;
  end

  lsq_dep_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dep (
    .flags    (flags_q),
    .addr     (addr_q),
    .head     (head_q),
    .ld_ready (ld_ready)
  );

  lsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .req   (ld_ready),
    .head  (head_q),
    .found (ld_issue_valid),
    .idx   (ld_issue_idx)
  );

  assign ld_issue_addr  = addr_q[ld_issue_idx];
  assign st_issue_idx   = head_q;
  assign st_issue_addr  = addr_q[head_q];
  assign st_issue_valid = flags_q[head_q].valid && flags_q[head_q].is_store &&
                          flags_q[head_q].addr_known && flags_q[head_q].committed &&
                          !flags_q[head_q].issued;

  assign flush_hit   = flush_valid && flags_q[flush_idx].valid;
  assign flush_age   = age[flush_idx];
  assign commit_hit  = commit_valid && flags_q[commit_idx].valid;
  assign addr_hit    = addr_valid && flags_q[addr_idx].valid;
  assign alloc_ready = (cnt_q < CNTW'(DEPTH)) && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;
  assign retire      = flags_q[head_q].valid && flags_q[head_q].committed &&
                       flags_q[head_q].issued;

  // Next-state process
  always_comb begin
    flags_n = flags_q;
    addr_n  = addr_q;
    head_n  = head_q;
    tail_n  = tail_q;
    cnt_n   = cnt_q;
    if (addr_hit) begin
      addr_n[addr_idx]             = addr_value;
      flags_n[addr_idx].addr_known = 1'b1;
    end
    if (commit_hit)     flags_n[commit_idx].committed = 1'b1;
    if (ld_issue_valid) flags_n[ld_issue_idx].issued  = 1'b1;
    if (st_issue_valid) flags_n[head_q].issued        = 1'b1;
    if (retire) begin
      flags_n[head_q] = '0;
      head_n          = head_q + IDXW'(1);
    end
    if (flush_hit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (age[i] > flush_age) flags_n[i] = '0;
      end
      tail_n = flush_idx + IDXW'(1);
      cnt_n  = CNTW'(flush_age) + CNTW'(1) - CNTW'(retire);
    end else begin
      tail_n = tail_q + IDXW'(alloc_fire);
      cnt_n  = cnt_q + CNTW'(alloc_fire) - CNTW'(retire);
    end
    if (alloc_fire) begin
      flags_n[tail_q]          = '0;
      flags_n[tail_q].valid    = 1'b1;
      flags_n[tail_q].is_store = alloc_is_store;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      cnt_q   <= cnt_n;
      flags_q <= flags_n;
    end
  end

  // Address storage, written only through its enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (addr_hit && (addr_idx == IDXW'(i))) addr_q[i] <= addr_n[i];
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !flags_q[tail_q].valid);
  // R3
  ld_addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue_valid |-> flags_q[ld_issue_idx].addr_known);
  // R8
  issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue_valid |=> !(ld_issue_valid && ld_issue_idx == $past(ld_issue_idx)));
  // R9
  store_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_issue_valid |=> ##1 (head_q == $past(head_q, 2) + IDXW'(1)));
  // R10
  flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_hit |=> (alloc_idx == $past(flush_idx) + IDXW'(1)));
endmodule

// File: tb/tb_lsq_order_top.sv
module tb_lsq_order_top;
  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_is_store, alloc_ready;
  logic [2:0] alloc_idx, addr_idx, commit_idx, flush_idx, ld_issue_idx, st_issue_idx;
  logic addr_valid, commit_valid, flush_valid, ld_issue_valid, st_issue_valid;
  logic [31:0] addr_value, ld_issue_addr, st_issue_addr;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lsq_order_top dut (.*);

  typedef struct packed {
    logic al; logic st; logic av; logic [2:0] ai; logic [7:0] ad;
    logic cv; logic [2:0] ci; logic fv; logic [2:0] fi;
    logic elv; logic [2:0] eli; logic esv; logic [2:0] esi; logic erdy; logic [2:0] eai;
  } vec_t;

  // Inputs: al st av ai ad cv ci fv fi | expected: ld_v ld_i st_v st_i ready alloc_idx
  localparam vec_t VEC [15] = '{
    '{1,0,0,0,8'h00,0,0,0,0, 0,0,0,0,1,0},  // R1 load e0
    '{1,1,0,0,8'h00,0,0,0,0, 0,0,0,0,1,1},  // R3 store e1, e0 no address
    '{1,0,1,0,8'h10,0,0,0,0, 0,0,0,0,1,2},  // R1 load e2
    '{1,0,1,2,8'h20,0,0,0,0, 1,0,0,0,1,3},  // R5 e0 has no older store
    '{0,0,1,3,8'h30,0,0,0,0, 0,0,0,0,1,4},  // R4 e2 behind unresolved store
    '{0,0,1,1,8'h20,0,0,0,0, 0,0,0,0,1,4},  // R4 e3 behind unresolved store
    '{0,0,0,0,8'h00,0,0,0,0, 1,3,0,0,1,4},  // R5 e2 matches, e3 differs
    '{0,0,0,0,8'h00,1,0,0,0, 0,0,0,0,1,4},  // R7 store not committed
    '{0,0,0,0,8'h00,1,1,0,0, 0,0,0,0,1,4},  // R9 e0 retires
    '{0,0,0,0,8'h00,0,0,0,0, 0,0,1,1,1,4},  // R7 store at head released
    '{0,0,0,0,8'h00,0,0,0,0, 0,0,0,0,1,4},  // R5 e2 still held
    '{0,0,0,0,8'h00,0,0,0,0, 1,2,0,0,1,4},  // R5 store gone, e2 goes
    '{0,0,0,0,8'h00,1,2,0,0, 0,0,0,0,1,4},  // R8
    '{0,0,0,0,8'h00,1,3,0,0, 0,0,0,0,1,4},  // R9
    '{0,0,0,0,8'h00,0,0,0,0, 0,0,0,0,1,4}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic al, input logic st, input logic av, input logic [2:0] ai,
                       input logic [31:0] ad, input logic cv, input logic [2:0] ci,
                       input logic fv, input logic [2:0] fi);
    alloc_valid = al; alloc_is_store = st; addr_valid = av; addr_idx = ai; addr_value = ad;
    commit_valid = cv; commit_idx = ci; flush_valid = fv; flush_idx = fi;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic ld_is(input string tag, input logic v, input logic [2:0] i);
    chk(tag, {ld_issue_valid, (v ? ld_issue_idx : 3'd0)}, {v, i});
  endtask

  task automatic st_is(input string tag, input logic v, input logic [2:0] i);
    chk(tag, {st_issue_valid, (v ? st_issue_idx : 3'd0)}, {v, i});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 reset", {alloc_ready, alloc_idx, ld_issue_valid, st_issue_valid}, {1'b1, 3'd0, 1'b0, 1'b0});
    rst_n = 1'b1;

    foreach (VEC[n]) begin
      drive(VEC[n].al, VEC[n].st, VEC[n].av, VEC[n].ai, {24'h0, VEC[n].ad},
            VEC[n].cv, VEC[n].ci, VEC[n].fv, VEC[n].fi);
      checks++;
      if (ld_issue_valid !== VEC[n].elv || (VEC[n].elv && ld_issue_idx !== VEC[n].eli) ||
          st_issue_valid !== VEC[n].esv || (VEC[n].esv && st_issue_idx !== VEC[n].esi) ||
          alloc_ready !== VEC[n].erdy || alloc_idx !== VEC[n].eai) begin
        fails++;
        $display("FAIL vector %0d (R1..R9 stream): actual %b_%0d_%b_%0d_%b_%0d expected %b_%0d_%b_%0d_%b_%0d",
                 n, ld_issue_valid, ld_issue_idx, st_issue_valid, st_issue_idx, alloc_ready, alloc_idx,
                 VEC[n].elv, VEC[n].eli, VEC[n].esv, VEC[n].esi, VEC[n].erdy, VEC[n].eai);
      end
      nxt();
    end

    // R6 oldest-first: store e4 unresolved, loads e5..e7 resolved behind it
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0); chk("R1 wrap index", alloc_idx, 4); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); nxt();
    drive(0, 0, 1, 7, 32'h70, 0, 0, 0, 0); nxt();
    drive(0, 0, 1, 6, 32'h60, 0, 0, 0, 0); nxt();
    drive(0, 0, 1, 5, 32'h50, 0, 0, 0, 0); nxt();
    drive(0, 0, 1, 4, 32'h44, 0, 0, 0, 0); ld_is("R4 all held", 0, 0); nxt();
    idle(); ld_is("R6 oldest first", 1, 5); chk("R6 address", ld_issue_addr, 32'h50); nxt();
    idle(); ld_is("R6 second", 1, 6); nxt();
    idle(); ld_is("R6 third", 1, 7); nxt();
    drive(0, 0, 0, 0, 0, 1, 4, 0, 0); ld_is("R8 none left", 0, 0); nxt();
    drive(0, 0, 0, 0, 0, 1, 5, 0, 0); st_is("R7 store e4", 1, 4); nxt();
    drive(0, 0, 0, 0, 0, 1, 6, 0, 0); nxt();
    drive(0, 0, 0, 0, 0, 1, 7, 0, 0); nxt();
    idle(); nxt();
    idle(); nxt();
    idle(); chk("R9 drained", {alloc_ready, alloc_idx}, {1'b1, 3'd0}); nxt();

    // R10 flush: keep e0, drop e1 and e2
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0); chk("R10 no alloc in flush", alloc_ready, 0); nxt();
    drive(0, 0, 1, 1, 32'h11, 0, 0, 0, 0); chk("R10 tail after flush", alloc_idx, 1); nxt();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0); ld_is("R10 stale address", 0, 0); nxt();
    drive(0, 0, 1, 0, 32'h10, 0, 0, 0, 0); ld_is("R10 fresh entry", 0, 0); nxt();
    idle(); ld_is("R3 e0 resolved", 1, 0); nxt();
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0); ld_is("R8 e0 once", 0, 0); nxt();
    drive(0, 0, 1, 1, 32'h12, 0, 0, 0, 0); nxt();
    idle(); ld_is("R10 new e1", 1, 1); chk("R10 new e1 addr", ld_issue_addr, 32'h12); nxt();
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0); nxt();
    idle(); nxt();

    // R2 fill all entries with stores starting at index 2
    for (int k = 0; k < 8; k++) begin
      drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 fill order", {alloc_ready, alloc_idx}, {1'b1, 3'((2 + k) % 8)});
      nxt();
    end
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0); chk("R2 full", {alloc_ready, alloc_idx}, {1'b0, 3'd2}); nxt();
    drive(0, 0, 1, 3, 32'h6, 0, 0, 0, 0); chk("R2 ignored", {alloc_ready, alloc_idx}, {1'b0, 3'd2}); nxt();
    drive(0, 0, 0, 0, 0, 1, 3, 0, 0); nxt();
    drive(0, 0, 1, 2, 32'h5, 0, 0, 0, 0); st_is("R7 not at head", 0, 0); nxt();
    drive(0, 0, 0, 0, 0, 1, 2, 0, 0); st_is("R7 uncommitted", 0, 0); nxt();
    idle(); st_is("R7 head store", 1, 2); chk("R7 address", st_issue_addr, 32'h5); nxt();
    idle(); st_is("R8 store once", 0, 0); nxt();
    idle(); st_is("R9 next head", 1, 3); chk("R9 slot freed", {alloc_ready, alloc_idx}, {1'b1, 3'd2}); nxt();

    // R11 reset while occupied
    rst_n = 1'b0;
    #1;
    chk("R11 reset mid-run", {alloc_ready, alloc_idx, ld_issue_valid, st_issue_valid}, {1'b1, 3'd0, 1'b0, 1'b0});
    nxt();
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule